// File: doc/BRIEF.md
# Descriptor Ring Queue Walker

This block handles one endpoint direction of a queue-based DMA engine. Software builds a ring of 16-byte descriptors in memory and gives the block a start address. The block fetches each descriptor one word at a time over a simple word request port. It checks whether hardware owns the descriptor and passes the buffer address and length to a separate data mover. When the data mover reports completion, the block writes status back and hands the descriptor back to software. It then follows the next-descriptor pointer.

Each descriptor holds four 32-bit words at byte offsets 0x0, 0x4, 0x8 and 0xC:
- offset 0x0: the control/info word;
- offset 0x4: the next-descriptor address;
- offset 0x8: the buffer address;
- offset 0xC: the length word.

The direction is fixed by the `IS_RX` parameter, and transmit and receive read their length from different fields. When the block finds a descriptor that software has not released, it stops and shows idle. A resume command makes it fetch that same descriptor again. A one-cycle interrupt pulse marks each completed descriptor that asked for one.

Top module: `dq_ring_walker`

## Requirements
- R1: After reset the block is idle (`idle`=1), with no memory request, no transfer request and no interrupt.
- R2: A `start` pulse loads `start_addr` and fetches the descriptor there. The fetches are reads at offsets 0x0, 0x4, 0x8 and 0xC, in that order, before any transfer request for it.
- R3: If word 0 bit 0 (hardware-own) reads as 0, the block stops and shows idle. It then makes no further memory or transfer request. A `resume` pulse re-reads word 0 of that same descriptor.
- R4: A descriptor with word 0 bit 2 (bypass) and bit 0 both set is skipped, and only its words at 0x0 and 0x4 are read. It makes no transfer request, no write and no interrupt, and the block continues at its next-descriptor address.
- R5: In transmit mode the transfer request carries:
  - the buffer address from word 2 (offset 0x8);
  - the length from word 3 bits 15:0;
  - a zero-length-packet flag from word 3 bit 29.
- R6: In receive mode the transfer request carries the allowed length from word 0 bits 31:16, with the zero-length-packet flag 0. On completion, word 3 is written back. Bits 15:0 become the smaller of the reported received length and the allowed length, and bits 31:16 keep their read value.
- R7: On completion, word 0 is written back with bit 0 cleared and every other bit unchanged. In transmit mode word 3 is never written.
- R8: `irq` is a one-cycle pulse, raised after the word-0 writeback only when word 0 bit 7 of that descriptor is set. Word 0 bit 1 has no effect.
- R9: After each completed or skipped descriptor the block fetches from its next-descriptor address, so a ring wraps back to earlier descriptors.
- R10: A memory request keeps the same address, direction and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin walking at `start_addr` (taken while idle) |
| start_addr | input | ADDR_W | Byte address of the first descriptor |
| resume | input | 1 | Re-fetch the current descriptor (taken while idle) |
| idle | output | 1 | Walker stopped |
| irq | output | 1 | Completion interrupt pulse |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted / read data valid |
| xfer_valid | output | 1 | Transfer request to the data mover |
| xfer_buf | output | 32 | Buffer address |
| xfer_len | output | LEN_W | Length to send or allowed to receive |
| xfer_zlp | output | 1 | Append a zero-length packet |
| xfer_done | input | 1 | Data mover finished |
| xfer_rx_len | input | LEN_W | Bytes received, valid with `xfer_done` |

## Verification
A memory read is answered one cycle after the request first shows, and the walker moves on at the next edge. So each descriptor word costs two cycles. A transfer request is completed on the same schedule, and `irq` rises in the cycle after the word-0 write is acknowledged.

The bench models record every read address, write, transfer and interrupt at the edge where it happens. Each scenario waits until `idle` returns and then compares memory contents and these logs with values worked out from the requirements. This keeps the checks independent of exact cycle counts, while the embedded properties hold the per-cycle handshake rules.

// File: rtl/dq_pkg.sv
package dq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_XFER, ST_WB3, ST_WB0
   } dq_state_e;

   localparam int unsigned OWN_BIT   = 0;
   localparam int unsigned SKIP_BIT  = 2;
   localparam int unsigned IRQ_BIT   = 7;
   localparam int unsigned ZLP_BIT   = 29;
   localparam int unsigned RXCAP_LSB = 16;

   localparam logic [3:0] OFS_INFO0 = 4'h0;
   localparam logic [3:0] OFS_NEXT  = 4'h4;
   localparam logic [3:0] OFS_BUF   = 4'h8;
   localparam logic [3:0] OFS_INFO3 = 4'hC;

   typedef struct packed {
      logic own;
      logic skip;
      logic irq_req;
   } dq_flags_t;
endpackage

// File: rtl/dq_len_clip.sv
module dq_len_clip #(
   parameter int unsigned LEN_W = 16
) (
   input  logic [LEN_W-1:0] len_in,
   input  logic [LEN_W-1:0] len_max,
   output logic [LEN_W-1:0] len_out
);
   always_comb begin
      if (len_in > len_max) len_out = len_max;
      else                  len_out = len_in;
   end
endmodule

// File: rtl/dq_desc_decode.sv
module dq_desc_decode
   import dq_pkg::*;
#(
   parameter int unsigned LEN_W = 16,
   parameter bit          IS_RX = 1'b0
) (
   input  logic [31:0]      info0,
   input  logic [31:0]      info3,
   input  logic [LEN_W-1:0] rx_len,
   output dq_flags_t        flags,
   output logic [LEN_W-1:0] req_len,
   output logic             req_zlp,
   output logic [31:0]      wb_info0,
   output logic [31:0]      wb_info3
);
   logic unused_in;
   assign unused_in = ^{info0, info3, rx_len};

   assign flags.own     = info0[OWN_BIT];
   assign flags.skip    = info0[SKIP_BIT];
   assign flags.irq_req = info0[IRQ_BIT];

   always_comb begin
      wb_info0          = info0;
      wb_info0[OWN_BIT] = 1'b0;
   end

   generate
      if (IS_RX) begin : g_rx
         logic [LEN_W-1:0] cap;
         logic [LEN_W-1:0] clipped;
         assign cap = info0[RXCAP_LSB +: LEN_W];
         dq_len_clip #(.LEN_W(LEN_W)) u_clip (
            .len_in (rx_len),
            .len_max(cap),
            .len_out(clipped)
         );
         assign req_len = cap;
         assign req_zlp = 1'b0;
         always_comb begin
            wb_info3              = info3;
            wb_info3[LEN_W-1:0]   = clipped;
         end
      end else begin : g_tx
         assign req_len  = info3[LEN_W-1:0];
         assign req_zlp  = info3[ZLP_BIT];
         assign wb_info3 = info3;
      end
   endgenerate
endmodule

// File: rtl/dq_ring_walker.sv
module dq_ring_walker
   import dq_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 16,
   parameter bit          IS_RX  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              resume,
   output logic              idle,
   output logic              irq,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   output logic              xfer_valid,
   output logic [31:0]       xfer_buf,
   output logic [LEN_W-1:0]  xfer_len,
   output logic              xfer_zlp,
   input  logic              xfer_done,
   input  logic [LEN_W-1:0]  xfer_rx_len
);
   localparam dq_state_e AFTER_XFER = IS_RX ? ST_WB3 : ST_WB0;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("dq_ring_walker: ADDR_W must lie in 8..32");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("dq_ring_walker: LEN_W must lie in 1..16");
      end
   endgenerate

   dq_state_e         state_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] next_q;
   logic [31:0]       info0_q;
   logic [31:0]       buf_q;
   logic [31:0]       info3_q;
   logic [LEN_W-1:0]  rxlen_q;
   logic              irq_q;
   logic [3:0]        ofs;

   dq_flags_t        flags;
   logic [LEN_W-1:0] req_len;
   logic             req_zlp;
   logic [31:0]      wb_info0;
   logic [31:0]      wb_info3;

   dq_desc_decode #(.LEN_W(LEN_W), .IS_RX(IS_RX)) u_dec (
      .info0   (info0_q),
      .info3   (info3_q),
      .rx_len  (rxlen_q),
      .flags   (flags),
      .req_len (req_len),
      .req_zlp (req_zlp),
      .wb_info0(wb_info0),
      .wb_info3(wb_info3)
   );

   always_comb begin
      unique case (state_q)
         ST_RD0, ST_WB0: ofs = OFS_INFO0;
         ST_RD1:         ofs = OFS_NEXT;
         ST_RD2:         ofs = OFS_BUF;
         ST_RD3, ST_WB3: ofs = OFS_INFO3;
         default:        ofs = OFS_INFO0;
      endcase
   end

   assign mem_addr   = cur_q + ADDR_W'(ofs);
   assign mem_req    = (state_q == ST_RD0) || (state_q == ST_RD1) ||
                       (state_q == ST_RD2) || (state_q == ST_RD3) ||
                       (state_q == ST_WB3) || (state_q == ST_WB0);
   assign mem_we     = (state_q == ST_WB3) || (state_q == ST_WB0);
   assign mem_wdata  = (state_q == ST_WB3) ? wb_info3 : wb_info0;
   assign xfer_valid = (state_q == ST_XFER);
   assign xfer_buf   = buf_q;
   assign xfer_len   = req_len;
   assign xfer_zlp   = req_zlp;
   assign idle       = (state_q == ST_IDLE);
   assign irq        = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         next_q  <= '0;
         info0_q <= '0;
         buf_q   <= '0;
         info3_q <= '0;
         rxlen_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  cur_q   <= start_addr;
                  state_q <= ST_RD0;
               end else if (resume) begin
                  state_q <= ST_RD0;
               end
            end
            ST_RD0: if (mem_ack) begin
               info0_q <= mem_rdata;
               state_q <= mem_rdata[OWN_BIT] ? ST_RD1 : ST_IDLE;
            end
            ST_RD1: if (mem_ack) begin
               next_q <= mem_rdata[ADDR_W-1:0];
               if (flags.skip) begin
                  cur_q   <= mem_rdata[ADDR_W-1:0];
                  state_q <= ST_RD0;
               end else begin
                  state_q <= ST_RD2;
               end
            end
            ST_RD2: if (mem_ack) begin
               buf_q   <= mem_rdata;
               state_q <= ST_RD3;
            end
            ST_RD3: if (mem_ack) begin
               info3_q <= mem_rdata;
               state_q <= ST_XFER;
            end
            ST_XFER: if (xfer_done) begin
               rxlen_q <= xfer_rx_len;
               state_q <= AFTER_XFER;
            end
            ST_WB3: if (mem_ack) begin
               state_q <= ST_WB0;
            end
            ST_WB0: if (mem_ack) begin
               irq_q   <= flags.irq_req;
               cur_q   <= next_q;
               state_q <= ST_RD0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !mem_req && !xfer_valid); // R3

   AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_done |=> xfer_valid && $stable(xfer_buf) && $stable(xfer_len)); // R5

   AST_WB0_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && (mem_addr[3:0] == OFS_INFO0) |-> !mem_wdata[OWN_BIT]); // R7

   AST_SKIP_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_ack && (mem_addr[3:0] == OFS_NEXT) && flags.skip |=> !xfer_valid && !mem_we); // R4

   generate
      if (!IS_RX) begin : g_tx_chk
         AST_TX_NO_LEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req && mem_we |-> mem_addr[3:0] != OFS_INFO3); // R7
      end else begin : g_rx_chk
         AST_RX_NO_ZLP: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_valid |-> !xfer_zlp); // R6
      end
   endgenerate
endmodule

// File: tb/tb_dq_model.sv
module tb_dq_model (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mem_req,
   input  logic        mem_we,
   input  logic [31:0] mem_addr,
   input  logic [31:0] mem_wdata,
   output logic [31:0] mem_rdata,
   output logic        mem_ack,
   input  logic        xfer_valid,
   input  logic [31:0] xfer_buf,
   input  logic [15:0] xfer_len,
   input  logic        xfer_zlp,
   output logic        xfer_done,
   output logic [15:0] xfer_rx_len,
   input  logic        irq
);
   logic [31:0] mem [64];
   logic [15:0] rx_tab [8];
   logic [31:0] rd_log [32];
   logic [31:0] xbuf [8];
   logic [15:0] xlen [8];
   logic        xzlp [8];
   int rd_cnt, wr_cnt, x_cnt, irq_cnt, hold_err;
   logic [31:0] addr_l;
   logic        we_l;

   initial begin
      rd_cnt = 0; wr_cnt = 0; x_cnt = 0; irq_cnt = 0; hold_err = 0;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      for (int i = 0; i < 8; i++) rx_tab[i] = '0;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; mem_rdata <= '0; xfer_done <= 1'b0; xfer_rx_len <= '0;
         addr_l <= '0; we_l <= 1'b0;
      end else begin
         if (mem_ack) begin
            if (!mem_req || mem_addr != addr_l || mem_we != we_l) hold_err <= hold_err + 1;
            mem_ack <= 1'b0;
         end else if (mem_req) begin
            mem_ack <= 1'b1;
            addr_l  <= mem_addr;
            we_l    <= mem_we;
            if (mem_we) begin
               mem[mem_addr[7:2]] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
            end else begin
               mem_rdata <= mem[mem_addr[7:2]];
               if (rd_cnt < 32) rd_log[rd_cnt] <= mem_addr;
               rd_cnt <= rd_cnt + 1;
            end
         end
         if (xfer_done) begin
            xfer_done <= 1'b0;
         end else if (xfer_valid) begin
            xfer_done   <= 1'b1;
            xfer_rx_len <= rx_tab[x_cnt % 8];
            xbuf[x_cnt % 8] <= xfer_buf;
            xlen[x_cnt % 8] <= xfer_len;
            xzlp[x_cnt % 8] <= xfer_zlp;
            x_cnt <= x_cnt + 1;
         end
         if (irq) irq_cnt <= irq_cnt + 1;
      end
   end
endmodule

// File: tb/tb_dq_ring_walker.sv
module tb_dq_ring_walker;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic        start_t = 0, resume_t = 0, start_r = 0, resume_r = 0;
   logic        idle_t, irq_t, req_t, we_t, ack_t, xv_t, xz_t, xd_t;
   logic [31:0] addr_t, wd_t, rd_t, xb_t;
   logic [15:0] xl_t, xr_t;
   logic        idle_r, irq_r, req_r, we_r, ack_r, xv_r, xz_r, xd_r;
   logic [31:0] addr_r, wd_r, rd_r, xb_r;
   logic [15:0] xl_r, xr_r;

   dq_ring_walker #(.ADDR_W(32), .LEN_W(16), .IS_RX(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .start(start_t), .start_addr(32'h0), .resume(resume_t),
      .idle(idle_t), .irq(irq_t), .mem_req(req_t), .mem_we(we_t), .mem_addr(addr_t),
      .mem_wdata(wd_t), .mem_rdata(rd_t), .mem_ack(ack_t), .xfer_valid(xv_t),
      .xfer_buf(xb_t), .xfer_len(xl_t), .xfer_zlp(xz_t), .xfer_done(xd_t), .xfer_rx_len(xr_t));
   tb_dq_model m_tx (
      .clk(clk), .rst_n(rst_n), .mem_req(req_t), .mem_we(we_t), .mem_addr(addr_t),
      .mem_wdata(wd_t), .mem_rdata(rd_t), .mem_ack(ack_t), .xfer_valid(xv_t),
      .xfer_buf(xb_t), .xfer_len(xl_t), .xfer_zlp(xz_t), .xfer_done(xd_t),
      .xfer_rx_len(xr_t), .irq(irq_t));

   dq_ring_walker #(.ADDR_W(32), .LEN_W(16), .IS_RX(1'b1)) dut_rx (
      .clk(clk), .rst_n(rst_n), .start(start_r), .start_addr(32'h0), .resume(resume_r),
      .idle(idle_r), .irq(irq_r), .mem_req(req_r), .mem_we(we_r), .mem_addr(addr_r),
      .mem_wdata(wd_r), .mem_rdata(rd_r), .mem_ack(ack_r), .xfer_valid(xv_r),
      .xfer_buf(xb_r), .xfer_len(xl_r), .xfer_zlp(xz_r), .xfer_done(xd_r), .xfer_rx_len(xr_r));
   tb_dq_model m_rx (
      .clk(clk), .rst_n(rst_n), .mem_req(req_r), .mem_we(we_r), .mem_addr(addr_r),
      .mem_wdata(wd_r), .mem_rdata(rd_r), .mem_ack(ack_r), .xfer_valid(xv_r),
      .xfer_buf(xb_r), .xfer_len(xl_r), .xfer_zlp(xz_r), .xfer_done(xd_r),
      .xfer_rx_len(xr_r), .irq(irq_r));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_idle(input bit rx);
      int n;
      repeat (3) @(negedge clk);
      n = 0;
      while (!(rx ? idle_r : idle_t) && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk("R3 walker returns to idle", {31'b0, rx ? idle_r : idle_t}, 32'h1);
   endtask

   task automatic test_reset();
      chk("R1 idle after reset", {31'b0, idle_t}, 32'h1);
      chk("R1 no mem request after reset", {30'b0, req_t, req_r}, 32'h0);
      chk("R1 no irq after reset", {30'b0, irq_t, irq_r}, 32'h0);
      chk("R1 no transfer after reset", {30'b0, xv_t, xv_r}, 32'h0);
   endtask

   task automatic test_tx_walk();
      m_tx.mem[0]  = 32'h0000_0083; m_tx.mem[1]  = 32'h10;
      m_tx.mem[2]  = 32'h100;       m_tx.mem[3]  = 32'h2000_0040;
      m_tx.mem[4]  = 32'h0000_0085; m_tx.mem[5]  = 32'h20;
      m_tx.mem[6]  = 32'h999;       m_tx.mem[7]  = 32'h11;
      m_tx.mem[8]  = 32'h0000_0001; m_tx.mem[9]  = 32'h30;
      m_tx.mem[10] = 32'h200;       m_tx.mem[11] = 32'h0000_0007;
      m_tx.mem[12] = 32'h0000_0080; m_tx.mem[13] = 32'h0;
      m_tx.mem[14] = 32'h300;       m_tx.mem[15] = 32'h2000_0005;
      @(negedge clk) start_t = 1'b1;
      @(negedge clk) start_t = 1'b0;
      wait_idle(1'b0);
      chk("R2 first read offset 0x0", m_tx.rd_log[0], 32'h0);
      chk("R2 second read offset 0x4", m_tx.rd_log[1], 32'h4);
      chk("R2 third read offset 0x8", m_tx.rd_log[2], 32'h8);
      chk("R2 fourth read offset 0xC", m_tx.rd_log[3], 32'hC);
      chk("R4 bypass reads only two words", m_tx.rd_log[6], 32'h20);
      chk("R4 transfer count skips bypass", m_tx.x_cnt, 2);
      chk("R4 bypass descriptor untouched", m_tx.mem[4], 32'h0000_0085);
      chk("R5 tx buffer", m_tx.xbuf[0], 32'h100);
      chk("R5 tx length", {16'h0, m_tx.xlen[0]}, 32'h40);
      chk("R5 tx zlp set", {31'b0, m_tx.xzlp[0]}, 32'h1);
      chk("R5 tx second buffer", m_tx.xbuf[1], 32'h200);
      chk("R5 tx second length", {16'h0, m_tx.xlen[1]}, 32'h7);
      chk("R5 tx zlp clear", {31'b0, m_tx.xzlp[1]}, 32'h0);
      chk("R7 word0 released, other bits kept", m_tx.mem[0], 32'h0000_0082);
      chk("R7 second word0 released", m_tx.mem[8], 32'h0);
      chk("R7 tx length word not written", m_tx.mem[3], 32'h2000_0040);
      chk("R7 tx write count", m_tx.wr_cnt, 2);
      chk("R8 one irq, only bit7 descriptor", m_tx.irq_cnt, 1);
      chk("R3 stopped on unowned descriptor", m_tx.rd_log[10], 32'h30);
      chk("R3 stop read count", m_tx.rd_cnt, 11);
   endtask

   task automatic test_tx_resume();
      @(negedge clk) resume_t = 1'b1;
      @(negedge clk) resume_t = 1'b0;
      wait_idle(1'b0);
      chk("R3 resume re-reads same descriptor", m_tx.rd_log[11], 32'h30);
      chk("R3 no transfer while still unowned", m_tx.x_cnt, 2);
      m_tx.mem[12] = 32'h0000_0081;
      @(negedge clk) resume_t = 1'b1;
      @(negedge clk) resume_t = 1'b0;
      wait_idle(1'b0);
      chk("R3 resumed transfer taken", m_tx.x_cnt, 3);
      chk("R5 resumed buffer", m_tx.xbuf[2], 32'h300);
      chk("R8 irq after resume", m_tx.irq_cnt, 2);
      chk("R9 ring wraps to first descriptor", m_tx.rd_log[m_tx.rd_cnt-1], 32'h0);
      chk("R10 request held until ack (tx)", m_tx.hold_err, 0);
   endtask

   task automatic test_rx_walk();
      m_rx.mem[0] = 32'h0020_0081; m_rx.mem[1] = 32'h10;
      m_rx.mem[2] = 32'h400;       m_rx.mem[3] = 32'h1234_0000;
      m_rx.mem[4] = 32'h0080_0081; m_rx.mem[5] = 32'h0;
      m_rx.mem[6] = 32'h500;       m_rx.mem[7] = 32'hABCD_FFFF;
      m_rx.rx_tab[0] = 16'h0050;
      m_rx.rx_tab[1] = 16'h0030;
      @(negedge clk) start_r = 1'b1;
      @(negedge clk) start_r = 1'b0;
      wait_idle(1'b1);
      chk("R6 rx allowed length first", {16'h0, m_rx.xlen[0]}, 32'h20);
      chk("R6 rx allowed length second", {16'h0, m_rx.xlen[1]}, 32'h80);
      chk("R6 rx zlp zero", {31'b0, m_rx.xzlp[0]}, 32'h0);
      chk("R6 rx length clipped", m_rx.mem[3], 32'h1234_0020);
      chk("R6 rx length below cap", m_rx.mem[7], 32'hABCD_0030);
      chk("R7 rx word0 released", m_rx.mem[0], 32'h0020_0080);
      chk("R7 rx second word0 released", m_rx.mem[4], 32'h0080_0080);
      chk("R7 rx write count", m_rx.wr_cnt, 4);
      chk("R8 rx irq count", m_rx.irq_cnt, 2);
      chk("R9 rx two-entry ring wraps", m_rx.rd_log[m_rx.rd_cnt-1], 32'h0);
      chk("R10 request held until ack (rx)", m_rx.hold_err, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_tx_walk();
      test_tx_resume();
      test_rx_walk();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule